// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits behind a plain 32-bit register port with single-cycle read and write strobes. Software arms it by choosing an interval code and setting an enable bit. From then on it must keep issuing a special reload command, or the countdown runs out. The countdown is paced by an external tick that pulses once every half second. When the interval runs out, the block does one of two things, depending on the configured action: it raises a system reset output for a fixed number of clock cycles, or it only sets a sticky expiry flag that software can read and clear.

To guard against runaway code, the configuration and mode registers accept a write only when the upper half-word of the write data carries a fixed key. The reload command also has to match an exact bit pattern. The interval codes do not scale linearly: the low codes step in whole seconds, the middle codes step in two-second increments, and every code from the top of the range upward saturates at sixteen seconds.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `sys_rst_o` is low and a read of configuration (0x14) or mode (0x18) returns zero, so the block starts disabled with code 0 and action 00.
- R2: A write to configuration or mode takes effect only when wdata[31:16] equals 0x16AA. A write with any other upper half-word leaves the register unchanged.
- R3: Mode holds the enable bit in bit 0 and the interval code in bits 7:4. Configuration holds the action in bits 1:0 and the expiry flag in bit 8. All other read bits, including 31:16, read as zero, and a control (0x10) read returns zero.
- R4: Interval code 0 gives 1 tick. Codes 1 to 6 give 2, 4, 6, 8, 10 and 12 ticks. Codes 7 to 11 give 16, 20, 24, 28 and 32 ticks.
- R5: Interval codes 12 to 15 each give 32 ticks.
- R6: A control write restarts the countdown only when wdata[12:0] equals 0x14AF, which is bit 0 set and 0xA57 in bits 12:1. Any other control write has no effect.
- R7: A reload, or a keyed mode write, discards all ticks already counted. Expiry then takes the full programmed number of further ticks.
- R8: On expiry with action 01, `sys_rst_o` rises in the cycle after the clock edge that sampled the final tick and stays high for exactly 16 cycles.
- R9: On expiry with any action other than 01, `sys_rst_o` stays low and configuration bit 8 becomes 1. The flag stays set until a keyed configuration write with bit 8 set clears it.
- R10: While disabled, ticks are not counted and the block never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| tick | input | 1 | Half-second pacing pulse, one clock wide |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with its default parameters: a 16-cycle reset pulse, an 8-bit offset and a 6-bit elapsed counter. Because the pacing tick is a port, the bench drives it directly, and even the 32-tick maximum interval costs only a few dozen cycles. That lets a table sweep all sixteen interval codes end to end, including the saturated top codes. Directed tests then cover the key guard, malformed reload patterns, the flag path and the disabled state.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int          DATA_W     = 32;
    localparam int          OFF_W      = 8;
    localparam int          CODE_W     = 4;
    localparam int          ELAPSED_W  = 6;
    localparam logic [OFF_W-1:0] OFF_CTRL = 8'h10;
    localparam logic [OFF_W-1:0] OFF_CFG  = 8'h14;
    localparam logic [OFF_W-1:0] OFF_MODE = 8'h18;
    localparam logic [15:0] WR_KEY      = 16'h16AA;
    localparam logic [12:0] RELOAD_CMD  = 13'h14AF;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_SYSRST = 2'b01,
        ACT_RSV2  = 2'b10,
        ACT_RSV3  = 2'b11
    } action_e;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        action_e           action;
        logic              flag;
    } ctl_state_t;

    function automatic logic [ELAPSED_W-1:0] code_ticks(input logic [CODE_W-1:0] c);
        int v;
        if (c == '0)            v = 1;
        else if (c <= 4'd6)     v = 2 * int'(c);
        else if (c <= 4'd11)    v = 4 * int'(c) - 12;
        else                    v = 32;
        return ELAPSED_W'(v);
    endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output ctl_state_t        st,
    output logic              restart,
    output logic [DATA_W-1:0] rdata
);
    logic keyed, cfg_wr, mode_wr, ctrl_cmd, flag_set, flag_clr;

    assign keyed    = (wdata[31:16] == WR_KEY);
    assign cfg_wr   = wr_en && (addr == OFF_CFG)  && keyed;
    assign mode_wr  = wr_en && (addr == OFF_MODE) && keyed;
    assign ctrl_cmd = wr_en && (addr == OFF_CTRL) && (wdata[12:0] == RELOAD_CMD);
    assign restart  = ctrl_cmd || mode_wr;
    assign flag_set = expire && (st.action != ACT_SYSRST);
    assign flag_clr = cfg_wr && wdata[8];

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{en: 1'b0, code: '0, action: ACT_NONE, flag: 1'b0};
        end else begin
            if (mode_wr) begin
                st.en   <= wdata[0];
                st.code <= wdata[7:4];
            end
            if (cfg_wr) st.action <= action_e'(wdata[1:0]);
            if (flag_set)      st.flag <= 1'b1;
            else if (flag_clr) st.flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (addr)
                OFF_CFG:  rdata <= {23'd0, st.flag, 6'd0, st.action};
                OFF_MODE: rdata <= {24'd0, st.code, 3'd0, st.en};
                default:  rdata <= '0;
            endcase
        end
    end

    p_key_cfg_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_CFG && wdata[31:16] != WR_KEY) |=> $stable(st.action));
    p_key_mode_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_MODE && wdata[31:16] != WR_KEY) |=> ($stable(st.en) && $stable(st.code)));
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (st.flag && !(wr_en && addr == OFF_CFG && wdata[31:16] == WR_KEY && wdata[8])) |=> st.flag);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic              restart,
    input  logic              tick,
    output logic              expire
);
    logic [ELAPSED_W-1:0] elapsed;
    logic [ELAPSED_W-1:0] limit;
    logic [ELAPSED_W:0]   next_cnt;

    assign limit    = code_ticks(code);
    assign next_cnt = {1'b0, elapsed} + 1'b1;
    assign expire   = en && !restart && tick && (next_cnt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !en || restart || expire) elapsed <= '0;
        else if (tick)                       elapsed <= next_cnt[ELAPSED_W-1:0];
    end

    p_elapsed_bound_r4: assert property (@(posedge clk) disable iff (rst)
        en |-> (elapsed < limit));
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!en && tick) |=> (elapsed == '0));
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse
    import kwd_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);
    localparam int LEFT_W = $clog2(RST_CYCLES + 1);
    logic [LEFT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)            left <= '0;
        else if (fire)      left <= LEFT_W'(RST_CYCLES);
        else if (left != 0) left <= left - 1'b1;
    end

    assign active = (left != '0);

    p_start_r8: assert property (@(posedge clk) disable iff (rst)
        fire |=> active);
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!fire && !active) |=> !active);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    output logic              sys_rst_o
);
    ctl_state_t st;
    logic restart, expire, fire;

    kwd_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .expire(expire), .st(st), .restart(restart), .rdata(rdata)
    );

    kwd_counter u_cnt (
        .clk(clk), .rst(rst), .en(st.en), .code(st.code),
        .restart(restart), .tick(tick), .expire(expire)
    );

    assign fire = expire && (st.action == ACT_SYSRST);

    kwd_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk(clk), .rst(rst), .fire(fire), .active(sys_rst_o)
    );

    p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        (!st.en && !sys_rst_o) |=> !sys_rst_o);
endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEYHI = 32'h16AA0000;

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic sys_rst_o;
    int n_chk = 0, n_fail = 0;

    keyed_watchdog u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .sys_rst_o(sys_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {code[3:0], expected ticks[5:0]}
    localparam logic [9:0] VEC [16] = '{
        {4'd0, 6'd1},  {4'd1, 6'd2},  {4'd2, 6'd4},  {4'd3, 6'd6},
        {4'd4, 6'd8},  {4'd5, 6'd10}, {4'd6, 6'd12}, {4'd7, 6'd16},
        {4'd8, 6'd20}, {4'd9, 6'd24}, {4'd10, 6'd28}, {4'd11, 6'd32},
        {4'd12, 6'd32}, {4'd13, 6'd32}, {4'd14, 6'd32}, {4'd15, 6'd32}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic tk();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    // counts cycles sys_rst_o is high, starting with the current sample
    task automatic pulse_len(output int n);
        n = 0;
        for (int i = 0; i < 24; i++) begin
            if (sys_rst_o) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] r;
        int len;
        logic early;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 sysrst", {31'd0, sys_rst_o}, 32'd0);
        rd(8'h14, r); chk("R1 cfg", r, 32'd0);
        rd(8'h18, r); chk("R1 mode", r, 32'd0);

        // R2 bad key dropped
        wr(8'h14, 32'h12340001);
        rd(8'h14, r); chk("R2 cfg bad key", r, 32'd0);
        wr(8'h18, 32'h16AB00B1);
        rd(8'h18, r); chk("R2 mode bad key", r, 32'd0);
        wr(8'h14, KEYHI | 32'h1);
        rd(8'h14, r); chk("R2 cfg keyed", r, 32'h1);

        // R3 readback layout
        wr(8'h18, KEYHI | 32'hFFB0);
        rd(8'h18, r); chk("R3 mode layout", r, 32'h000000B0);
        rd(8'h10, r); chk("R3 ctrl reads zero", r, 32'd0);

        // R4 / R5 sweep of all codes with action 01
        for (int v = 0; v < 16; v++) begin
            logic [3:0] c;
            logic [5:0] n;
            c = VEC[v][9:6];
            n = VEC[v][5:0];
            wr(8'h18, KEYHI | {24'd0, c, 4'h1});
            wr(8'h10, 32'h000014AF);
            early = 1'b0;
            for (int t = 0; t < int'(n) - 1; t++) begin
                tk();
                if (sys_rst_o) early = 1'b1;
            end
            chk(c >= 4'd12 ? "R5 no early expiry" : "R4 no early expiry", {31'd0, early}, 32'd0);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            chk(c >= 4'd12 ? "R5 expiry on last tick" : "R4 expiry on last tick",
                {31'd0, sys_rst_o}, 32'd1);
            if (v == 0) begin
                pulse_len(len);
                chk("R8 pulse length", len, 32'd16);
            end else begin
                idle(20);
            end
        end

        // R6 malformed reloads ignored; code 1 = 2 ticks
        wr(8'h18, KEYHI | 32'h11);
        tk();
        wr(8'h10, 32'h000014AE);
        wr(8'h10, 32'h000014AD);
        wr(8'h10, 32'h00000A57);
        chk("R6 not yet expired", {31'd0, sys_rst_o}, 32'd0);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R6 bad reload ignored", {31'd0, sys_rst_o}, 32'd1);
        idle(20);

        // R7 reload restarts
        tk();
        wr(8'h10, 32'hFFFF14AF);
        tk();
        chk("R7 reload restarts", {31'd0, sys_rst_o}, 32'd0);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R7 expiry after full interval", {31'd0, sys_rst_o}, 32'd1);
        idle(20);

        // R9 flag action
        wr(8'h14, KEYHI | 32'h2);
        wr(8'h10, 32'h000014AF);
        tk(); tk();
        chk("R9 no reset on flag action", {31'd0, sys_rst_o}, 32'd0);
        rd(8'h14, r); chk("R9 flag set", r, 32'h102);
        wr(8'h14, 32'h00000102);
        rd(8'h14, r); chk("R9 unkeyed clear ignored", r, 32'h102);
        wr(8'h14, KEYHI | 32'h102);
        rd(8'h14, r); chk("R9 keyed clear", r, 32'h002);

        // R10 disabled: no countdown
        wr(8'h14, KEYHI | 32'h1);
        wr(8'h18, KEYHI | 32'h0);
        early = 1'b0;
        for (int t = 0; t < 40; t++) begin
            tk();
            if (sys_rst_o) early = 1'b1;
        end
        chk("R10 no expiry while disabled", {31'd0, early}, 32'd0);
        rd(8'h18, r); chk("R10 mode disabled", r, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule